// File: doc/BRIEF.md
# Framebuffer Control Register Interface

This block is the memory-mapped register slave of a palette-based 8-bit framebuffer controller. A host master reaches it through a 21-bit byte offset space with single-cycle requests qualified by a 4-bit byte enable. Through that space it sets up the visible geometry, the control word, the start offset of the frame in video memory and the cursor position, and it loads a 256-entry colour palette, a 3-entry cursor colour table and a 512-entry cursor bitmap. The block presents the settled values, the decoded pixel depth and a lookup port into the colour palette to the scan-out engine, which lives outside it.

Horizontal and vertical geometry are kept in the scaled units the host writes: the horizontal field counts groups of four pixels and the vertical field counts half-lines. Narrow writes replace only the enabled byte lanes of the current 32-bit value. The interrupt line is raised by the scan-out engine at the end of a frame and dropped by any host write. A write to the soft-reset offset returns every register to zero and sweeps both stores back to zero in the background.

Top module: `fbctl_regs`

## Requirements
- R1: A read of offset 0x000000 returns 0x00000010; writes to that offset change nothing that can be read back.
- R2: Writing value v at offset 0x080118 sets the pixel width output to 4*v (v truncated to DIM_W bits); reading that offset returns v.
- R3: Writing value v at offset 0x080150 sets the line count output to v/2 (floor); reading that offset returns v with bit 0 cleared.
- R4: Offsets 0x080800 to 0x080FFF hold the colour palette, entry index = offset bits 10:3, red in data bits 23:16, green 15:8, blue 7:0; scan_rgb shows entry scan_idx one cycle after scan_idx is applied; host reads of this range return 0.
- R5: The cursor colour table has 3 entries at 0x080508, 0x080510 and 0x080518 (each 8-byte slot maps to one entry), 24 bits wide in the same colour packing, readable with bits 31:24 reading as 0.
- R6: Offsets 0x081000 to 0x081FFF hold the cursor bitmap, entry index = offset bits 11:3, 16 bits per entry, readable with bits 31:16 reading as 0.
- R7: pix_depth is decoded from control bits 22:20: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 15, 5 gives 16, 6 and 7 give 0.
- R8: Byte enable bit n selects data bits 8n+7:8n; a write replaces only the enabled lanes of the current value and keeps the rest; a read returns 0 in lanes not enabled.
- R9: A write to offset 0x180000 clears width, height, control word, top offset, cursor position and cursor colour table at once, raises mem_clear_busy for 512 cycles while both stores are zeroed, and host writes into the stores during that sweep are dropped; the same sweep runs after rst.
- R10: Every host write, to any offset, leaves irq low in the next cycle; frame_event sets irq when no write is present in the same cycle.
- R11: Writes to the timing offsets (0x080000, 0x080108 to 0x080170, 0x080200) and to any undecoded offset change no register; reads of them return 0.
- R12: A read request is answered with rsp_valid high and the data on rsp_rdata exactly one cycle later; rsp_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte offset of the request |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| frame_event | input | 1 | End-of-frame pulse from scan-out |
| irq | output | 1 | Interrupt line |
| scan_idx | input | CLR_AW | Colour palette lookup index |
| scan_rgb | output | 24 | Colour palette lookup result |
| mem_clear_busy | output | 1 | Store sweep in progress |
| disp_width | output | DIM_W+2 | Visible width in pixels |
| disp_height | output | DIM_W | Visible height in lines |
| ctrl_word | output | 32 | Control word |
| top_offset | output | 32 | Frame start offset in video memory |
| cursor_pos | output | 32 | Cursor position |
| pix_depth | output | 5 | Decoded bits per pixel |

## Verification
Random writes with random byte-enable patterns land on every register and on random entries of both stores, each followed by a read under an independent random enable: full-word enables show the scaling and the store packing, while partial enables separate a correct lane merge from one that overwrites or zeroes the kept lanes. Directed writes to the identifier, the timing offsets and an undecoded offset, followed by a read of every register, tell an ignored write from one that leaks into a neighbouring register. A walk over all eight control depth codes, an end-of-frame pulse colliding with a write, and a store write placed inside the reset sweep cover the decode table, the interrupt priority and the dropped write.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  localparam int ADDR_W = 21;

  localparam logic [ADDR_W-1:0] OFF_ID    = 21'h000000;
  localparam logic [ADDR_W-1:0] OFF_HDISP = 21'h080118;
  localparam logic [ADDR_W-1:0] OFF_VDISP = 21'h080150;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 21'h080300;
  localparam logic [ADDR_W-1:0] OFF_TOP   = 21'h080400;
  localparam logic [ADDR_W-1:0] OFF_CPAL  = 21'h080508;
  localparam logic [ADDR_W-1:0] OFF_CPOS  = 21'h080638;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 21'h080800;
  localparam logic [ADDR_W-1:0] OFF_PAT   = 21'h081000;
  localparam logic [ADDR_W-1:0] OFF_SRST  = 21'h180000;

  localparam logic [31:0] ID_VALUE  = 32'h0000_0010;
  localparam int          DEPTH_LSB = 20;

  // Bits per pixel for the 3-bit depth code of the control word.
  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic word_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] off);
    return a[ADDR_W-1:2] == off[ADDR_W-1:2];
  endfunction

endpackage

// File: rtl/fbctl_lane_ram.sv
// Simple dual-port store: one write port with byte-lane enables and one
// registered read port, one array per lane so that block RAM is inferred.
module fbctl_lane_ram #(
  parameter int LANES = 2,
  parameter int AW    = 9
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LANES-1:0]   wlane,
  input  logic [AW-1:0]      waddr,
  input  logic [LANES*8-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [LANES*8-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wlane[g]) mem[waddr] <= wdata[g*8 +: 8];
      rdata[g*8 +: 8] <= mem[raddr];
    end
  end
endmodule

// File: rtl/fbctl_clear_seq.sv
// Walks every store address once after reset or soft reset.
module fbctl_clear_seq #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign addr = cnt_q;

  p_sweep_start_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy_q && cnt_q == '0))
    else $error("sweep did not restart");

  p_sweep_end_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == LAST && !start) |=> !busy_q)
    else $error("sweep ran past the last address");
endmodule

// File: rtl/fbctl_irq_ctl.sv
// Interrupt line: set by the end-of-frame pulse, dropped by any host write.
module fbctl_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_seen,
  input  logic frame_event,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst || wr_seen) irq_q <= 1'b0;
    else if (frame_event) irq_q <= 1'b1;
  end

  assign irq = irq_q;
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int CLR_AW = 8,
  parameter int PAT_AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [20:0]       req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              frame_event,
  output logic              irq,
  input  logic [CLR_AW-1:0] scan_idx,
  output logic [23:0]       scan_rgb,
  output logic              mem_clear_busy,
  output logic [DIM_W+1:0]  disp_width,
  output logic [DIM_W-1:0]  disp_height,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       top_offset,
  output logic [31:0]       cursor_pos,
  output logic [4:0]        pix_depth
);
  localparam int CPAL_N   = 3;
  localparam int CPAL_IW  = $clog2(CPAL_N);
  localparam int CPAL_SPAN = CPAL_N * 8;
  localparam int SWEEP_AW = (PAT_AW > CLR_AW) ? PAT_AW : CLR_AW;

  // ---------------- address decode ----------------
  logic              wr, rd;
  logic [20:0]       cpal_diff;
  logic              hit_cpal, hit_clr, hit_pat, soft_rst;
  logic [CPAL_IW-1:0] cpal_idx;
  logic [CLR_AW-1:0] clr_idx;
  logic [PAT_AW-1:0] pat_idx;
  logic [31:0]       mask;

  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;
  assign cpal_diff = req_addr - OFF_CPAL;
  assign hit_cpal  = cpal_diff < 21'(CPAL_SPAN);
  assign cpal_idx  = cpal_diff[3 +: CPAL_IW];
  assign hit_clr   = req_addr[20:CLR_AW+3] == OFF_CLR[20:CLR_AW+3];
  assign clr_idx   = req_addr[CLR_AW+2:3];
  assign hit_pat   = req_addr[20:PAT_AW+3] == OFF_PAT[20:PAT_AW+3];
  assign pat_idx   = req_addr[PAT_AW+2:3];
  assign soft_rst  = wr && word_hit(req_addr, OFF_SRST);
  assign mask      = lane_mask(req_be);

  // ---------------- register state ----------------
  logic [DIM_W-1:0] hd_q;      // width in groups of four pixels
  logic [DIM_W-1:0] ht_q;      // height in lines (written in half-lines)
  logic [31:0]      ctrl_q, top_q, cpos_q;
  logic [23:0]      cpal_q [CPAL_N];

  // Current value of the addressed register word (stores handled apart).
  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit_cpal)                          rd_word = {8'h00, cpal_q[cpal_idx]};
    else if (word_hit(req_addr, OFF_ID))    rd_word = ID_VALUE;
    else if (word_hit(req_addr, OFF_HDISP)) rd_word = 32'(hd_q);
    else if (word_hit(req_addr, OFF_VDISP)) rd_word = 32'({ht_q, 1'b0});
    else if (word_hit(req_addr, OFF_CTRL))  rd_word = ctrl_q;
    else if (word_hit(req_addr, OFF_TOP))   rd_word = top_q;
    else if (word_hit(req_addr, OFF_CPOS))  rd_word = cpos_q;
  end

  // Lane merge: enabled lanes from the bus, the others kept.
  logic [31:0] merged;
  assign merged = (req_wdata & mask) | (rd_word & ~mask);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      hd_q   <= '0;
      ht_q   <= '0;
      ctrl_q <= '0;
      top_q  <= '0;
      cpos_q <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal_q[i] <= '0;
    end else if (wr) begin
      if (hit_cpal)                          cpal_q[cpal_idx] <= merged[23:0];
      else if (word_hit(req_addr, OFF_HDISP)) hd_q   <= merged[DIM_W-1:0];
      else if (word_hit(req_addr, OFF_VDISP)) ht_q   <= merged[DIM_W:1];
      else if (word_hit(req_addr, OFF_CTRL))  ctrl_q <= merged;
      else if (word_hit(req_addr, OFF_TOP))   top_q  <= merged;
      else if (word_hit(req_addr, OFF_CPOS))  cpos_q <= merged;
    end
  end

  // ---------------- store sweep ----------------
  logic                sweep_busy;
  logic [SWEEP_AW-1:0] sweep_addr;

  fbctl_clear_seq #(.AW(SWEEP_AW)) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .start (soft_rst),
    .busy  (sweep_busy),
    .addr  (sweep_addr)
  );

  assign mem_clear_busy = sweep_busy;

  // ---------------- colour palette ----------------
  logic              clr_we;
  logic [CLR_AW-1:0] clr_waddr;
  logic [23:0]       clr_wdata;

  assign clr_we    = sweep_busy || (wr && hit_clr);
  assign clr_waddr = sweep_busy ? sweep_addr[CLR_AW-1:0] : clr_idx;
  assign clr_wdata = sweep_busy ? 24'h0 : merged[23:0];

  fbctl_lane_ram #(.LANES(3), .AW(CLR_AW)) u_clr (
    .clk   (clk),
    .we    (clr_we),
    .wlane (3'b111),
    .waddr (clr_waddr),
    .wdata (clr_wdata),
    .raddr (scan_idx),
    .rdata (scan_rgb)
  );

  // ---------------- cursor bitmap ----------------
  logic              pat_we;
  logic [1:0]        pat_lane;
  logic [PAT_AW-1:0] pat_waddr;
  logic [15:0]       pat_wdata, pat_rdata;

  assign pat_we    = sweep_busy || (wr && hit_pat);
  assign pat_lane  = sweep_busy ? 2'b11 : req_be[1:0];
  assign pat_waddr = sweep_busy ? sweep_addr[PAT_AW-1:0] : pat_idx;
  assign pat_wdata = sweep_busy ? 16'h0 : req_wdata[15:0];

  fbctl_lane_ram #(.LANES(2), .AW(PAT_AW)) u_pat (
    .clk   (clk),
    .we    (pat_we),
    .wlane (pat_lane),
    .waddr (pat_waddr),
    .wdata (pat_wdata),
    .raddr (pat_idx),
    .rdata (pat_rdata)
  );

  // ---------------- read response ----------------
  logic        rsp_valid_q, rd_pat_q;
  logic [31:0] rd_word_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rd_pat_q    <= 1'b0;
      rd_word_q   <= '0;
      mask_q      <= '0;
    end else begin
      rsp_valid_q <= rd;
      if (rd) begin
        rd_pat_q  <= hit_pat;
        rd_word_q <= rd_word & mask;
        mask_q    <= mask;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rd_pat_q ? ({16'h0, pat_rdata} & mask_q) : rd_word_q;

  // ---------------- interrupt ----------------
  fbctl_irq_ctl u_irq (
    .clk         (clk),
    .rst         (rst),
    .wr_seen     (wr),
    .frame_event (frame_event),
    .irq         (irq)
  );

  // ---------------- outputs to scan-out ----------------
  assign disp_width  = {hd_q, 2'b00};
  assign disp_height = ht_q;
  assign ctrl_word   = ctrl_q;
  assign top_offset  = top_q;
  assign cursor_pos  = cpos_q;
  assign pix_depth   = depth_of(ctrl_q[DEPTH_LSB +: 3]);

  // ---------------- assertions ----------------
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !irq)
    else $error("irq high after a write");

  p_irq_set_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_event && !(req_valid && req_write)) |=> irq)
    else $error("frame event did not raise irq");

  p_rsp_one_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid)
    else $error("read not answered next cycle");

  p_rsp_none_r12: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid)
    else $error("spurious response");

  p_srst_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && word_hit(req_addr, OFF_SRST))
      |=> (ctrl_word == '0 && disp_width == '0 && mem_clear_busy))
    else $error("soft reset did not clear");

  p_id_const_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && word_hit(req_addr, OFF_ID) && req_be == 4'hF)
      |=> rsp_rdata == ID_VALUE)
    else $error("identifier read wrong");

  always_ff @(posedge clk) begin
    if (!rst) begin
      p_depth_legal_r7: assert (pix_depth inside {5'd0, 5'd1, 5'd2, 5'd4,
                                                  5'd8, 5'd15, 5'd16})
        else $error("illegal depth");
    end
  end
endmodule

// File: tb/tb_fbctl_regs.sv
module tb_fbctl_regs;
  localparam int DIM_W  = 12;
  localparam int CLR_AW = 8;
  localparam int PAT_AW = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst, req_valid, req_write, frame_event;
  logic [20:0]       req_addr;
  logic [3:0]        req_be;
  logic [31:0]       req_wdata;
  logic              rsp_valid, irq, mem_clear_busy;
  logic [31:0]       rsp_rdata, ctrl_word, top_offset, cursor_pos;
  logic [CLR_AW-1:0] scan_idx;
  logic [23:0]       scan_rgb;
  logic [DIM_W+1:0]  disp_width;
  logic [DIM_W-1:0]  disp_height;
  logic [4:0]        pix_depth;

  fbctl_regs #(.DIM_W(DIM_W), .CLR_AW(CLR_AW), .PAT_AW(PAT_AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .frame_event(frame_event),
    .irq(irq), .scan_idx(scan_idx), .scan_rgb(scan_rgb),
    .mem_clear_busy(mem_clear_busy), .disp_width(disp_width),
    .disp_height(disp_height), .ctrl_word(ctrl_word), .top_offset(top_offset),
    .cursor_pos(cursor_pos), .pix_depth(pix_depth)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // ---------------- model from the requirements ----------------
  logic [DIM_W-1:0] m_hd, m_ht;
  logic [31:0]      m_ctrl, m_top, m_cpos;
  logic [23:0]      m_cpal [3];
  logic [15:0]      m_pat  [512];
  logic [23:0]      m_clr  [256];

  function automatic logic [31:0] f_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [4:0] f_depth(input logic [2:0] c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4: return 15; 5: return 16; default: return 0;
    endcase
  endfunction

  function automatic bit in_cpal(input logic [20:0] a);
    return a >= 21'h080508 && a < 21'h080520;
  endfunction
  function automatic bit in_pat(input logic [20:0] a);
    return a >= 21'h081000 && a < 21'h082000;
  endfunction
  function automatic bit in_clr(input logic [20:0] a);
    return a >= 21'h080800 && a < 21'h081000;
  endfunction

  function automatic logic [31:0] m_word(input logic [20:0] a);
    logic [20:0] w = {a[20:2], 2'b00};
    if (in_cpal(a)) return {8'h0, m_cpal[(a - 21'h080508) >> 3]};
    if (in_pat(a))  return {16'h0, m_pat[a[11:3]]};
    case (w)
      21'h000000: return 32'h10;
      21'h080118: return 32'(m_hd);
      21'h080150: return 32'({m_ht, 1'b0});
      21'h080300: return m_ctrl;
      21'h080400: return m_top;
      21'h080638: return m_cpos;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [20:0] a, input logic [3:0] be,
                         input logic [31:0] d);
    logic [31:0] m  = f_mask(be);
    logic [31:0] nw = (d & m) | (m_word(a) & ~m);
    logic [20:0] w  = {a[20:2], 2'b00};
    if (in_clr(a))       m_clr[a[10:3]] = nw[23:0];
    else if (in_cpal(a)) m_cpal[(a - 21'h080508) >> 3] = nw[23:0];
    else if (in_pat(a))  m_pat[a[11:3]] = nw[15:0];
    else case (w)
      21'h080118: m_hd   = nw[DIM_W-1:0];
      21'h080150: m_ht   = nw[DIM_W:1];
      21'h080300: m_ctrl = nw;
      21'h080400: m_top  = nw;
      21'h080638: m_cpos = nw;
      default: ;
    endcase
  endtask

  task automatic m_clear_all();
    m_hd = 0; m_ht = 0; m_ctrl = 0; m_top = 0; m_cpos = 0;
    for (int i = 0; i < 3; i++)   m_cpal[i] = 0;
    for (int i = 0; i < 512; i++) m_pat[i] = 0;
    for (int i = 0; i < 256; i++) m_clr[i] = 0;
  endtask

  // ---------------- check and bus tasks ----------------
  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [20:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [20:0] a, input logic [3:0] be,
                        output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 0;
  endtask

  task automatic rd_chk(input string req, input logic [20:0] a,
                        input logic [3:0] be);
    logic [31:0] d; logic v;
    bus_rd(a, be, d, v);
    chk(req, d, m_word(a) & f_mask(be));
  endtask

  task automatic scan_chk(input string req, input logic [7:0] idx);
    @(negedge clk); scan_idx = idx;
    @(negedge clk);
    chk(req, 32'(scan_rgb), 32'(m_clr[idx]));
  endtask

  task automatic wait_sweep();
    int n = 0;
    while (mem_clear_busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic all_regs_chk(input string req);
    rd_chk(req, 21'h080118, 4'hF);
    rd_chk(req, 21'h080150, 4'hF);
    rd_chk(req, 21'h080300, 4'hF);
    rd_chk(req, 21'h080400, 4'hF);
    rd_chk(req, 21'h080638, 4'hF);
    for (int k = 0; k < 3; k++) rd_chk(req, 21'h080508 + 21'(k * 8), 4'hF);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d; logic v;
    logic [20:0] a; logic [3:0] be; logic [31:0] wd;
    void'($urandom(32'd4242));
    rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_be = 0;
    req_wdata = 0; frame_event = 0; scan_idx = 0;
    m_clear_all();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 busy after rst", 32'(mem_clear_busy), 1);
    wait_sweep();

    // reset state
    chk("R10 reset irq", 32'(irq), 0);
    chk("R12 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R7 reset depth", 32'(pix_depth), 1);
    all_regs_chk("R9 reset regs");
    scan_chk("R4 reset palette", 8'd77);

    // R1 identifier and ignored write
    rd_chk("R1 id", 21'h000000, 4'hF);
    bus_wr(21'h000000, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R1 id after write", 21'h000000, 4'hF);

    // R12 response timing
    bus_rd(21'h000000, 4'hF, d, v);
    chk("R12 rsp_valid", 32'(v), 1);
    @(negedge clk);
    chk("R12 rsp_valid idle", 32'(rsp_valid), 0);

    // R2 / R3 directed
    bus_wr(21'h080118, 4'hF, 32'd320);
    m_write(21'h080118, 4'hF, 32'd320);
    chk("R2 width out", 32'(disp_width), 32'd1280);
    rd_chk("R2 width read", 21'h080118, 4'hF);
    bus_wr(21'h080150, 4'hF, 32'd2049);
    m_write(21'h080150, 4'hF, 32'd2049);
    chk("R3 height out", 32'(disp_height), 32'd1024);
    rd_chk("R3 height read", 21'h080150, 4'hF);

    // R7 depth codes
    for (int c = 0; c < 8; c++) begin
      bus_wr(21'h080300, 4'hF, 32'(c) << 20 | 32'h0000_0400);
      m_write(21'h080300, 4'hF, 32'(c) << 20 | 32'h0000_0400);
      chk("R7 depth", 32'(pix_depth), 32'(f_depth(3'(c))));
    end

    // R8 byte lane merge on the control word
    bus_wr(21'h080300, 4'hF, 32'h1122_3344);
    m_write(21'h080300, 4'hF, 32'h1122_3344);
    bus_wr(21'h080302, 4'b0100, 32'h00AA_0000);
    m_write(21'h080302, 4'b0100, 32'h00AA_0000);
    chk("R8 merge", ctrl_word, 32'h11AA_3344);
    rd_chk("R8 narrow read", 21'h080300, 4'b0010);

    // R4 host read of palette returns 0
    bus_wr(21'h080800 + 21'(9 * 8), 4'hF, 32'h00C0_FFEE);
    m_write(21'h080800 + 21'(9 * 8), 4'hF, 32'h00C0_FFEE);
    bus_rd(21'h080800 + 21'(9 * 8), 4'hF, d, v);
    chk("R4 palette read zero", d, 0);
    scan_chk("R4 palette scan", 8'd9);

    // R11 timing and undecoded writes
    bus_wr(21'h080000, 4'hF, 32'hDEAD_BEEF);
    bus_wr(21'h080108, 4'hF, 32'hDEAD_BEEF);
    bus_wr(21'h080170, 4'hF, 32'hDEAD_BEEF);
    bus_wr(21'h080200, 4'hF, 32'hDEAD_BEEF);
    bus_wr(21'h0A0000, 4'hF, 32'hDEAD_BEEF);
    all_regs_chk("R11 regs unchanged");
    rd_chk("R11 timing read zero", 21'h080108, 4'hF);
    rd_chk("R11 undecoded read zero", 21'h0A0000, 4'hF);

    // R10 interrupt
    @(negedge clk); frame_event = 1;
    @(negedge clk); frame_event = 0;
    chk("R10 set", 32'(irq), 1);
    bus_wr(21'h080200, 4'hF, 0);
    chk("R10 clear on write", 32'(irq), 0);
    @(negedge clk);
    frame_event = 1; req_valid = 1; req_write = 1; req_addr = 21'h080000;
    req_be = 4'hF;
    @(negedge clk);
    frame_event = 0; req_valid = 0; req_write = 0;
    chk("R10 write wins", 32'(irq), 0);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int kind = $urandom_range(0, 6);
      be = 4'($urandom);
      wd = $urandom;
      case (kind)
        0: a = 21'h080118;
        1: a = 21'h080150;
        2: a = 21'h080300;
        3: a = 21'h080400;
        4: a = 21'h080508 + 21'($urandom_range(0, 2) * 8 + $urandom_range(0, 1) * 4);
        5: a = 21'h081000 + 21'($urandom_range(0, 511) * 8 + $urandom_range(0, 1) * 4);
        default: a = 21'h080800 + 21'($urandom_range(0, 255) * 8);
      endcase
      if (kind == 6) a = a + 21'($urandom_range(0, 1) * 4);
      bus_wr(a, be, wd);
      m_write(a, be, wd);
      chk("R10 irq low after write", 32'(irq), 0);
      case (kind)
        0: begin chk("R2 width out", 32'(disp_width), 32'({m_hd, 2'b00}));
                 rd_chk("R2 R8 width read", a, 4'($urandom)); end
        1: begin chk("R3 height out", 32'(disp_height), 32'(m_ht));
                 rd_chk("R3 R8 height read", a, 4'($urandom)); end
        2: begin chk("R7 depth", 32'(pix_depth), 32'(f_depth(m_ctrl[22:20])));
                 rd_chk("R8 ctrl read", a, 4'($urandom)); end
        3: begin chk("R8 top out", top_offset, m_top);
                 rd_chk("R8 top read", a, 4'($urandom)); end
        4: rd_chk("R5 cursor colour", a, 4'($urandom));
        5: rd_chk("R6 cursor bitmap", a, 4'($urandom));
        default: scan_chk("R4 palette", a[10:3]);
      endcase
    end

    // R9 soft reset and dropped store write
    bus_wr(21'h080638, 4'hF, 32'h0004_5006);
    m_write(21'h080638, 4'hF, 32'h0004_5006);
    chk("R8 cursor pos out", cursor_pos, 32'h0004_5006);
    bus_wr(21'h180000, 4'hF, 0);
    chk("R9 busy", 32'(mem_clear_busy), 1);
    chk("R9 ctrl cleared", ctrl_word, 0);
    chk("R9 cursor cleared", cursor_pos, 0);
    bus_wr(21'h081000, 4'hF, 32'h0000_BEEF);
    bus_wr(21'h080800, 4'hF, 32'h00AB_CDEF);
    m_clear_all();
    wait_sweep();
    chk("R9 sweep done", 32'(mem_clear_busy), 0);
    rd_chk("R9 bitmap write dropped", 21'h081000, 4'hF);
    scan_chk("R9 palette write dropped", 8'd0);
    scan_chk("R9 palette cleared", 8'd9);
    all_regs_chk("R9 regs cleared");
    for (int k = 0; k < 8; k++)
      rd_chk("R9 bitmap cleared", 21'h081000 + 21'($urandom_range(0, 511) * 8), 4'hF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule